// File: doc/BRIEF.md
# Two-Wire Bus Bit Timing Generator

This block produces the clock-line and data-line waveforms for the master side of an I2C-style two-wire bus. A byte-level controller asks for one bus event at a time: a START, a repeated START, one data bit, or a STOP. The block works from a fast system clock. It drives two active-low open-drain enables, where 1 releases the line and 0 pulls it low. It raises `done` for one cycle when the event is complete.

Three fields set the bus rate: a low-phase divider, a high-phase divider and a power-of-two prescaler exponent. A clock-low phase lasts `low_div * 2^exp_sel + 4` system cycles. A clock-high phase lasts `high_div * 2^exp_sel + 4` system cycles. The START hold time, the repeated-START setup time and the STOP setup time each last one high phase. The fields are captured when a START is accepted and stay fixed until the next START.

The block samples the clock line while it releases it. It counts high time only while the line actually reads high, so a slow rise or a slave holding the clock low stretches the phase. It also samples the data line at the end of each data bit's high phase, which returns the bit a slave drove.

Top module: `twb_bit_timer`

## Requirements
- R1: After reset the block is idle: `busy` = 0, `done` = 0, `rx_bit` = 0, and both `scl_oe_n` and `sda_oe_n` are 1 (1 releases a line, 0 pulls it low).
- R2: Every clock-low phase holds `scl_oe_n` = 0 for exactly `low_div * 2^exp_sel + 4` cycles, using the captured fields.
- R3: Every clock-high phase holds `scl_oe_n` = 1 for `high_div * 2^exp_sel + 4` cycles in which `scl_in` reads 1. Cycles in which `scl_in` reads 0 are not counted and lengthen the phase.
- R4: A START (`req_op` = 0) pulls the data line low while the clock stays released for one high phase, then pulls the clock low.
- R5: A repeated START (`req_op` = 1) runs a low phase with data released, a high phase with data released, then a high phase with data pulled low, and then pulls the clock low.
- R6: A STOP (`req_op` = 3) runs a low phase with data low, a high phase with data low, then a high phase with data released. After it both lines are released.
- R7: A data bit (`req_op` = 2) sets `sda_oe_n` to `req_bit` in the first cycle of its low phase. It holds that value through the following high phase and after the bit, and then pulls the clock low.
- R8: At the last counted cycle of a data bit's high phase the block samples `sda_in` and presents the value on `rx_bit` in the same cycle that `done` rises.
- R9: A request is accepted on a clock edge where `req_valid` = 1 and `busy` = 0. `busy` is 1 from the next cycle until the last phase ends, and `done` is then 1 for exactly one cycle while `busy` returns to 0.
- R10: A request presented while `busy` = 1 is ignored: the waveform of the running event and those that follow are unchanged.
- R11: `low_div`, `high_div` and `exp_sel` are captured only when a START is accepted. Changes to them at any other time do not affect phase lengths until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe from the byte controller |
| req_op | input | 2 | Event: 0 START, 1 repeated START, 2 data bit, 3 STOP |
| req_bit | input | 1 | Data bit value for a data-bit request |
| low_div | input | DIV_W | Clock-low divider |
| high_div | input | DIV_W | Clock-high divider |
| exp_sel | input | EXP_W | Prescaler exponent (power of two) |
| scl_in | input | 1 | Sampled clock-line level, synchronous to clk |
| sda_in | input | 1 | Sampled data-line level, synchronous to clk |
| scl_oe_n | output | 1 | Clock-line enable, 0 pulls low |
| sda_oe_n | output | 1 | Data-line enable, 0 pulls low |
| busy | output | 1 | An event is in progress |
| done | output | 1 | One-cycle pulse at the end of an event |
| rx_bit | output | 1 | Data line sampled at the end of the last data bit |

## Verification
All outputs are registered, so an accepted request changes `busy` and both enables one cycle after the edge that samples `req_valid`. `done` and `rx_bit` update one cycle after the edge that counts the final phase cycle. A segment of N counted cycles therefore holds its line levels for N consecutive sampled cycles, plus one cycle for each uncounted cycle in which the clock line was held low. The bench keeps a queue-driven model that advances on the same edge and compares every output half a period later, on each falling clock. Any off-by-one in a phase length, a stretch or a pulse then shows up in a specific cycle.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_RESTART = 2'd1,
        OP_BIT     = 2'd2,
        OP_STOP    = 2'd3
    } op_e;

    // One timed segment of a bus event: line levels and whether it ends the event.
    typedef struct packed {
        logic scl;
        logic sda;
        logic last;
    } seg_t;

    // Segment sequence for each event; a segment with scl=1 lasts one high
    // phase, a segment with scl=0 lasts one low phase.
    function automatic seg_t seg_lookup(op_e op, logic [1:0] idx, logic b);
        seg_t s;
        s = '{scl: 1'b1, sda: 1'b1, last: 1'b1};
        case (op)
            OP_START: s = '{scl: 1'b1, sda: 1'b0, last: 1'b1};
            OP_RESTART: begin
                case (idx)
                    2'd0:    s = '{scl: 1'b0, sda: 1'b1, last: 1'b0};
                    2'd1:    s = '{scl: 1'b1, sda: 1'b1, last: 1'b0};
                    default: s = '{scl: 1'b1, sda: 1'b0, last: 1'b1};
                endcase
            end
            OP_BIT: begin
                if (idx == 2'd0) s = '{scl: 1'b0, sda: b, last: 1'b0};
                else             s = '{scl: 1'b1, sda: b, last: 1'b1};
            end
            default: begin
                case (idx)
                    2'd0:    s = '{scl: 1'b0, sda: 1'b0, last: 1'b0};
                    2'd1:    s = '{scl: 1'b1, sda: 1'b0, last: 1'b0};
                    default: s = '{scl: 1'b1, sda: 1'b1, last: 1'b1};
                endcase
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/twb_phase_len.sv
module twb_phase_len #(
    parameter int DIV_W = 8,
    parameter int EXP_W = 3,
    parameter int CNT_W = 16
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic [CNT_W-1:0] len_o
);

    // divider scaled by 2^exp, plus the fixed four-cycle overhead
    assign len_o = (CNT_W'(div_i) << exp_i) + CNT_W'(4);

endmodule

// File: rtl/twb_cfg_hold.sv
module twb_cfg_hold #(
    parameter int DIV_W = 8,
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] low_i,
    input  logic [DIV_W-1:0] high_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic [DIV_W-1:0] low_o,
    output logic [DIV_W-1:0] high_o,
    output logic [EXP_W-1:0] exp_o
);

    typedef struct packed {
        logic [DIV_W-1:0] low;
        logic [DIV_W-1:0] high;
        logic [EXP_W-1:0] expn;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.low  = low_i;
            cfg_d.high = high_i;
            cfg_d.expn = exp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign low_o  = cfg_q.low;
    assign high_o = cfg_q.high;
    assign exp_o  = cfg_q.expn;

endmodule

// File: rtl/twb_bit_timer.sv
module twb_bit_timer
    import twb_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_bit,
    input  logic [DIV_W-1:0] low_div,
    input  logic [DIV_W-1:0] high_div,
    input  logic [EXP_W-1:0] exp_sel,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe_n,
    output logic             sda_oe_n,
    output logic             busy,
    output logic             done,
    output logic             rx_bit
);

    localparam int MAX_SHIFT = (1 << EXP_W) - 1;
    localparam int CNT_W     = DIV_W + MAX_SHIFT + 1;
    localparam int N_PHASE   = 2;   // index 0: low phase, 1: high phase

    typedef struct packed {
        logic             active;
        op_e              op;
        logic [1:0]       idx;
        logic             bitv;
        logic [CNT_W-1:0] cnt;
        logic             scl;
        logic             sda;
        logic             done;
        logic             rx;
    } st_t;

    st_t st_d, st_q;

    logic             accept;
    logic             load_cfg;
    logic [DIV_W-1:0] held_low, held_high;
    logic [EXP_W-1:0] held_exp;
    logic [EXP_W-1:0] exp_src;
    logic [DIV_W-1:0] div_src [N_PHASE];
    logic [CNT_W-1:0] phase_len [N_PHASE];
    seg_t             cur_seg, nxt_seg, acc_seg;
    logic             tick;

    assign accept   = !st_q.active && req_valid;
    assign load_cfg = accept && (op_e'(req_op) == OP_START);

    twb_cfg_hold #(
        .DIV_W (DIV_W),
        .EXP_W (EXP_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_cfg),
        .low_i  (low_div),
        .high_i (high_div),
        .exp_i  (exp_sel),
        .low_o  (held_low),
        .high_o (held_high),
        .exp_o  (held_exp)
    );

    // A START uses the live fields in its own accept cycle; later events use the held copy.
    assign div_src[0] = load_cfg ? low_div  : held_low;
    assign div_src[1] = load_cfg ? high_div : held_high;
    assign exp_src    = load_cfg ? exp_sel  : held_exp;

    for (genvar g = 0; g < N_PHASE; g++) begin : g_len
        twb_phase_len #(
            .DIV_W (DIV_W),
            .EXP_W (EXP_W),
            .CNT_W (CNT_W)
        ) u_len (
            .div_i (div_src[g]),
            .exp_i (exp_src),
            .len_o (phase_len[g])
        );
    end

    assign cur_seg = seg_lookup(st_q.op, st_q.idx, st_q.bitv);
    assign nxt_seg = seg_lookup(st_q.op, st_q.idx + 2'd1, st_q.bitv);
    assign acc_seg = seg_lookup(op_e'(req_op), 2'd0, req_bit);

    // Low segments always count; high segments count only while the line reads high.
    assign tick = st_q.active && (!cur_seg.scl || scl_in);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.active = 1'b1;
            st_d.op     = op_e'(req_op);
            st_d.idx    = 2'd0;
            st_d.bitv   = req_bit;
            st_d.scl    = acc_seg.scl;
            st_d.sda    = acc_seg.sda;
            st_d.cnt    = acc_seg.scl ? phase_len[1] : phase_len[0];
        end else if (tick) begin
            if (st_q.cnt == CNT_W'(1)) begin
                if (st_q.op == OP_BIT && cur_seg.scl) begin
                    st_d.rx = sda_in;
                end
                if (cur_seg.last) begin
                    st_d.active = 1'b0;
                    st_d.done   = 1'b1;
                    st_d.scl    = (st_q.op == OP_STOP);
                end else begin
                    st_d.idx = st_q.idx + 2'd1;
                    st_d.scl = nxt_seg.scl;
                    st_d.sda = nxt_seg.sda;
                    st_d.cnt = nxt_seg.scl ? phase_len[1] : phase_len[0];
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.op     <= OP_START;
            st_q.scl    <= 1'b1;
            st_q.sda    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_oe_n = st_q.scl;
    assign sda_oe_n = st_q.sda;
    assign busy     = st_q.active;
    assign done     = st_q.done;
    assign rx_bit   = st_q.rx;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done) else $error("done longer than one cycle"); // R9

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && req_valid) |=> ($stable(st_q.op) && $stable(st_q.bitv))) else $error("request taken while busy"); // R10

    AST_BIT_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.op == OP_BIT && st_q.scl) |=> $stable(st_q.sda)) else $error("data moved with clock high"); // R7

    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.scl && !scl_in) |=> $stable(st_q.cnt)) else $error("high count ran with line low"); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |=> ($stable(held_low) && $stable(held_high) && $stable(held_exp))) else $error("fields changed mid event"); // R11

    AST_END_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && st_q.op != OP_STOP) |-> !st_q.scl) else $error("clock not held low after event"); // R4

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && st_q.op == OP_STOP) |-> (st_q.scl && st_q.sda)) else $error("lines not free after stop"); // R6

endmodule

// File: tb/twb_bit_timer_test.sv
module twb_bit_timer_test;

    localparam int DIV_W = 8;
    localparam int EXP_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_op = 2'd0;
    logic             req_bit = 1'b0;
    logic [DIV_W-1:0] low_div = '0;
    logic [DIV_W-1:0] high_div = '0;
    logic [EXP_W-1:0] exp_sel = '0;
    logic             slave_hold = 1'b0;
    logic             slave_sda = 1'b1;
    logic             scl_in, sda_in;
    logic             scl_oe_n, sda_oe_n, busy, done, rx_bit;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;   // 125 MHz

    assign scl_in = scl_oe_n & ~slave_hold;
    assign sda_in = sda_oe_n & slave_sda;

    twb_bit_timer #(.DIV_W(DIV_W), .EXP_W(EXP_W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_op   (req_op),
        .req_bit  (req_bit),
        .low_div  (low_div),
        .high_div (high_div),
        .exp_sel  (exp_sel),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_oe_n (scl_oe_n),
        .sda_oe_n (sda_oe_n),
        .busy     (busy),
        .done     (done),
        .rx_bit   (rx_bit)
    );

    // ---------------- reference model: queue of timed segments ----------------
    bit [1:0] seg_q[$];   // {scl, sda}
    int       len_q[$];
    int       m_rem = 0;
    int       m_op = 0;
    int       m_low = 0, m_high = 0, m_exp = 0;
    bit       m_scl = 1, m_sda = 1, m_done = 0, m_busy = 0, m_rx = 0;

    task automatic push_seg(input bit s, input bit d, input int n);
        seg_q.push_back({s, d});
        len_q.push_back(n);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            seg_q.delete(); len_q.delete();
            m_scl = 1; m_sda = 1; m_done = 0; m_busy = 0; m_rx = 0;
            m_low = 0; m_high = 0; m_exp = 0; m_rem = 0; m_op = 0;
        end else begin
            m_done = 0;
            if (seg_q.size() > 0) begin
                if (!m_scl || !slave_hold) m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    if (m_op == 2 && m_scl) m_rx = m_sda & slave_sda;
                    void'(seg_q.pop_front());
                    void'(len_q.pop_front());
                    if (seg_q.size() == 0) begin
                        m_done = 1; m_busy = 0;
                        m_scl = (m_op == 3);
                    end else begin
                        {m_scl, m_sda} = seg_q[0];
                        m_rem = len_q[0];
                    end
                end
            end else if (req_valid) begin
                int lo, hi;
                if (req_op == 2'd0) begin
                    m_low = int'(low_div); m_high = int'(high_div); m_exp = int'(exp_sel);
                end
                lo = m_low * (1 << m_exp) + 4;
                hi = m_high * (1 << m_exp) + 4;
                m_op = int'(req_op);
                case (req_op)
                    2'd0: push_seg(1, 0, hi);
                    2'd1: begin push_seg(0, 1, lo); push_seg(1, 1, hi); push_seg(1, 0, hi); end
                    2'd2: begin push_seg(0, req_bit, lo); push_seg(1, req_bit, hi); end
                    default: begin push_seg(0, 0, lo); push_seg(1, 0, hi); push_seg(1, 1, hi); end
                endcase
                m_busy = 1;
                {m_scl, m_sda} = seg_q[0];
                m_rem = len_q[0];
            end
        end
    end

    // ---------------- compare every cycle, half a period after the edge ----------------
    task automatic cmp(input string name, input logic act, input bit expv);
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s %s got %b expected %b at %0t", cur_req, name, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        vectors++;
        cmp("scl_oe_n", scl_oe_n, m_scl);
        cmp("sda_oe_n", sda_oe_n, m_sda);
        cmp("busy", busy, m_busy);
        cmp("done", done, m_done);
        cmp("rx_bit", rx_bit, m_rx);
    end

    // ---------------- stimulus ----------------
    task automatic tick_in;
        @(posedge clk); #2;
    endtask

    task automatic issue(input logic [1:0] op, input logic b);
        tick_in();
        while (m_busy) tick_in();
        req_valid = 1'b1; req_op = op; req_bit = b;
        tick_in();
        req_valid = 1'b0;
    endtask

    task automatic wait_idle;
        tick_in();
        while (m_busy) tick_in();
    endtask

    task automatic set_cfg(input int lo, input int hi, input int e);
        low_div = DIV_W'(lo); high_div = DIV_W'(hi); exp_sel = EXP_W'(e);
    endtask

    initial begin
        // R1: reset state and idle lines
        cur_req = "R1";
        repeat (3) tick_in();
        rst_n = 1'b1;
        repeat (4) tick_in();

        // L = 10, H = 8
        set_cfg(3, 2, 1);
        cur_req = "R4"; issue(2'd0, 1'b0); wait_idle();
        cur_req = "R7"; issue(2'd2, 1'b1); wait_idle();
        cur_req = "R8"; slave_sda = 1'b0; issue(2'd2, 1'b1); wait_idle(); slave_sda = 1'b1;
        cur_req = "R7"; issue(2'd2, 1'b0); wait_idle();
        cur_req = "R5"; issue(2'd1, 1'b0); wait_idle();

        // R3: slave holds the clock low across the high phase
        cur_req = "R3";
        tick_in(); slave_hold = 1'b1;
        issue(2'd2, 1'b1);
        repeat (20) tick_in();
        slave_hold = 1'b0;
        wait_idle();

        // R10: requests while busy
        cur_req = "R10";
        issue(2'd2, 1'b0);
        repeat (3) tick_in();
        req_valid = 1'b1; req_op = 2'd3; req_bit = 1'b1;
        tick_in();
        req_op = 2'd1;
        tick_in();
        req_valid = 1'b0;
        wait_idle();

        cur_req = "R6"; issue(2'd3, 1'b0); wait_idle();

        // R11: new fields apply only from the next START
        cur_req = "R11";
        set_cfg(0, 5, 0);           // L = 4, H = 9
        issue(2'd0, 1'b0);
        set_cfg(9, 9, 2);           // must not apply
        issue(2'd2, 1'b1);
        issue(2'd1, 1'b0);
        issue(2'd3, 1'b0);
        wait_idle();

        // R2: largest exponent, L = 132, H = 4
        cur_req = "R2";
        set_cfg(1, 0, 7);
        issue(2'd0, 1'b0);
        issue(2'd2, 1'b0);
        wait_idle();

        // R9: request held valid back to back, accepted the cycle busy drops
        cur_req = "R9";
        tick_in();
        req_valid = 1'b1; req_op = 2'd2; req_bit = 1'b1;
        tick_in();
        while (m_busy) tick_in();
        req_op = 2'd3;
        tick_in();
        req_valid = 1'b0;
        wait_idle();
        repeat (4) tick_in();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL %s watchdog expired", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule